// File: doc/BRIEF.md
# Dual-Read Register File with Falling-Edge Output Capture

This block is a small general-purpose register file: four entries, four bits each by default. It has one write port and two independent read ports. Writes commit on the rising clock edge. Each read port has its own output register. That register loads the addressed entry on the falling edge, so a value written at a rising edge can be read out half a clock later. A consumer that samples both read ports at the next rising edge therefore gets a full-cycle result from a single-cycle datapath.

A separate preload port writes chosen values into individual entries at the rising edge. It is used to give the file known starting contents, such as 1, 3 and 2 in entries 0, 1 and 2. The preload port has priority over the normal write port. All entries are ordinary storage, and entry 0 is not tied to zero.

Reset is asynchronous and active low. Its release passes through a two-flop synchronizer on the rising edge.

Top module: `regfile_dualread`

## Requirements
- R1: While reset is asserted (rst_n low), all entries and both read output registers are zero. The outputs go to zero without waiting for a clock edge.
- R2: When wr_en is high and pre_en is low at a rising edge, the entry selected by wr_addr takes the value on wr_data.
- R3: When wr_en and pre_en are both low at a rising edge, no entry changes.
- R4: rd_data_a and rd_data_b load the entry selected by rd_addr_a and rd_addr_b on the falling edge only. They hold their value across the rising edge, even when the read address has changed.
- R5: The two read ports are independent. Both ports may address the same entry, and both then show its value.
- R6: When a read address equals the address written at a rising edge, the following falling edge captures the newly written value.
- R7: When pre_en is high at a rising edge, the entry selected by pre_addr takes pre_data. Any normal write presented in the same cycle is discarded, whether or not it targets the same entry.
- R8: Entry 0 is general purpose and holds any written value, including nonzero ones.
- R9: A write to one entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: writes on the rising edge, read capture on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 2 | Entry selected for read port A |
| rd_addr_b | input | 2 | Entry selected for read port B |
| wr_en | input | 1 | Normal write request |
| wr_addr | input | 2 | Entry selected for the normal write |
| wr_data | input | 4 | Normal write value |
| pre_en | input | 1 | Preload request, has priority over wr_en |
| pre_addr | input | 2 | Entry selected for the preload |
| pre_data | input | 4 | Preload value |
| rd_data_a | output | 4 | Registered read result, port A |
| rd_data_b | output | 4 | Registered read result, port B |

## Verification
The hardest case to reach is the half-cycle window between a rising-edge write and the falling-edge capture. A test must show both that the new value appears right after the falling edge and that the output did not move at the rising edge before it. The stimulus drives all inputs just after a falling edge and reads the outputs at the same point one cycle later; this observes the write-then-read result. A directed test also changes a read address and samples the outputs just after the next rising edge, where they must still hold the old entry. The preload-versus-write conflict is exercised with the two ports aimed at different entries and also at the same entry. The result is checked at both targets.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    WSRC_NONE    = 2'd0,
    WSRC_PORT    = 2'd1,
    WSRC_PRELOAD = 2'd2
  } wsrc_e;
endpackage

// File: rtl/rf_write_arb.sv
module rf_write_arb #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pre_en,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  import rf_pkg::*;

  wsrc_e src;

  always_comb begin
    if (pre_en)     src = WSRC_PRELOAD;
    else if (wr_en) src = WSRC_PORT;
    else            src = WSRC_NONE;
  end

  always_comb begin
    commit_en   = 1'b0;
    commit_addr = '0;
    commit_data = '0;
    case (src)
      WSRC_PRELOAD: begin
        commit_en   = 1'b1;
        commit_addr = pre_addr;
        commit_data = pre_data;
      end
      WSRC_PORT: begin
        commit_en   = 1'b1;
        commit_addr = wr_addr;
        commit_data = wr_data;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit_en,
  input  logic [ADDR_W-1:0]             commit_addr,
  input  logic [DATA_W-1:0]             commit_data,
  output logic [DEPTH-1:0][DATA_W-1:0]  entries
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic              hit;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    assign hit = commit_en && (commit_addr == ADDR_W'(e));

    always_comb d = commit_data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= d;
    end

    assign entries[e] = q;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0][DATA_W-1:0]  entries,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_q
);
  logic [DATA_W-1:0] sel_d;

  always_comb sel_d = entries[rd_addr];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= sel_d;
  end
endmodule

// File: rtl/regfile_dualread.sv
module regfile_dualread #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pre_en,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int NPORTS = 2;

  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic                         commit_en;
  logic [ADDR_W-1:0]            commit_addr;
  logic [DATA_W-1:0]            commit_data;
  logic [DEPTH-1:0][DATA_W-1:0] entries;

  rf_write_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .pre_en      (pre_en),
    .pre_addr    (pre_addr),
    .pre_data    (pre_data),
    .commit_en   (commit_en),
    .commit_addr (commit_addr),
    .commit_data (commit_data)
  );

  rf_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .commit_en   (commit_en),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .entries     (entries)
  );

  logic [NPORTS-1:0][ADDR_W-1:0] port_addr;
  logic [NPORTS-1:0][DATA_W-1:0] port_q;

  assign port_addr[0] = rd_addr_a;
  assign port_addr[1] = rd_addr_b;

  for (genvar p = 0; p < NPORTS; p++) begin : g_rport
    rf_read_port #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rp (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .entries (entries),
      .rd_addr (port_addr[p]),
      .rd_q    (port_q[p])
    );
  end

  assign rd_data_a = port_q[0];
  assign rd_data_b = port_q[1];
endmodule

// File: rtl/regfile_dualread_chk.sv
module regfile_dualread_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              pre_en,
  input logic [ADDR_W-1:0] pre_addr,
  input logic [DATA_W-1:0] pre_data,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [DATA_W-1:0] rd_data_b
);
  logic              armed;
  logic [DATA_W-1:0] seen_a, seen_b;
  logic              cm_valid;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data;
  logic              hit_a, hit_b;
  logic [DATA_W-1:0] exp_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      seen_a   <= '0;
      seen_b   <= '0;
      cm_valid <= 1'b0;
      cm_addr  <= '0;
      cm_data  <= '0;
    end else begin
      armed    <= 1'b1;
      seen_a   <= rd_data_a;
      seen_b   <= rd_data_b;
      cm_valid <= pre_en | wr_en;
      cm_addr  <= pre_en ? pre_addr : wr_addr;
      cm_data  <= pre_en ? pre_data : wr_data;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_a <= 1'b0;
      hit_b <= 1'b0;
      exp_w <= '0;
    end else begin
      hit_a <= cm_valid && (rd_addr_a == cm_addr);
      hit_b <= cm_valid && (rd_addr_b == cm_addr);
      exp_w <= cm_data;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (rd_data_a == '0 && rd_data_b == '0));

  p_hold_a_r4: assert property (@(negedge clk) disable iff (!rst_n)
    armed |-> rd_data_a == seen_a);

  p_hold_b_r4: assert property (@(negedge clk) disable iff (!rst_n)
    armed |-> rd_data_b == seen_b);

  // R6 and R7: the value committed at a rising edge reaches a matching read port
  p_fwd_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |-> rd_data_a == exp_w);

  p_fwd_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |-> rd_data_b == exp_w);
endmodule

bind regfile_dualread regfile_dualread_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .rd_addr_a (rd_addr_a),
  .rd_addr_b (rd_addr_b),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .pre_en    (pre_en),
  .pre_addr  (pre_addr),
  .pre_data  (pre_data),
  .rd_data_a (rd_data_a),
  .rd_data_b (rd_data_b)
);

// File: tb/regfile_dualread_test.sv
`timescale 1ns/1ps
module regfile_dualread_test;
  logic       clk;
  logic       rst_n;
  logic [1:0] rd_addr_a, rd_addr_b, wr_addr, pre_addr;
  logic       wr_en, pre_en;
  logic [3:0] wr_data, pre_data;
  logic [3:0] rd_data_a, rd_data_b;

  int checks = 0;
  int fails  = 0;

  regfile_dualread uut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pre_en(pre_en), .pre_addr(pre_addr), .pre_data(pre_data),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
  );

  // 100 MHz, high a quarter of the period
  initial begin
    clk = 1'b0;
    #7.5;
    forever begin
      clk = 1'b1; #2.5;
      clk = 1'b0; #7.5;
    end
  end

  // {we, waddr, wdata, ra, rb, exp_a, exp_b}
  localparam logic [18:0] VEC [8] = '{
    {1'b1, 2'd3, 4'h5, 2'd3, 2'd1, 4'h5, 4'h3},
    {1'b1, 2'd2, 4'h4, 2'd2, 2'd0, 4'h4, 4'h1},
    {1'b0, 2'd1, 4'hF, 2'd1, 2'd2, 4'h3, 4'h4},
    {1'b1, 2'd0, 4'h7, 2'd0, 2'd0, 4'h7, 4'h7},
    {1'b1, 2'd1, 4'hA, 2'd3, 2'd2, 4'h5, 4'h4},
    {1'b0, 2'd0, 4'h0, 2'd1, 2'd0, 4'hA, 4'h7},
    {1'b1, 2'd3, 4'hF, 2'd3, 2'd3, 4'hF, 4'hF},
    {1'b1, 2'd2, 4'h0, 2'd2, 2'd1, 4'h0, 4'hA}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // returns just after a falling edge; the rising edge lies in between
  task automatic step();
    @(negedge clk);
    #2.5;
  endtask

  task automatic preload(input logic [1:0] a, input logic [3:0] d);
    pre_en = 1'b1; pre_addr = a; pre_data = d;
    step();
    pre_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rd_addr_a = '0; rd_addr_b = '0; wr_addr = '0; pre_addr = '0;
    wr_en = 1'b0; pre_en = 1'b0; wr_data = '0; pre_data = '0;
    step(); step();
    chk("R1 reset a", rd_data_a, 4'h0);
    chk("R1 reset b", rd_data_b, 4'h0);
    rst_n = 1'b1;
    step(); step(); step();

    // R7 preload of starting contents
    preload(2'd0, 4'h1);
    preload(2'd1, 4'h3);
    preload(2'd2, 4'h2);
    rd_addr_a = 2'd0; rd_addr_b = 2'd1;
    step();
    chk("R7 preload r0", rd_data_a, 4'h1);
    chk("R7 preload r1", rd_data_b, 4'h3);
    rd_addr_a = 2'd2; rd_addr_b = 2'd3;
    step();
    chk("R7 preload r2", rd_data_a, 4'h2);
    chk("R9 r3 untouched", rd_data_b, 4'h0);

    // vector table: R2 R3 R5 R6 R8 R9
    for (int i = 0; i < 8; i++) begin
      {wr_en, wr_addr, wr_data, rd_addr_a, rd_addr_b} = VEC[i][18:8];
      step();
      chk($sformatf("R2/R3/R6 vec%0d a", i), rd_data_a, VEC[i][7:4]);
      chk($sformatf("R5/R8/R9 vec%0d b", i), rd_data_b, VEC[i][3:0]);
    end
    wr_en = 1'b0;
    // state now r0=7 r1=A r2=0 r3=F

    // R4: change addresses, sample just past the rising edge
    rd_addr_a = 2'd0; rd_addr_b = 2'd3;
    #6;
    chk("R4 hold a over rise", rd_data_a, 4'h0);
    chk("R4 hold b over rise", rd_data_b, 4'hA);
    step();
    chk("R4 capture a at fall", rd_data_a, 4'h7);
    chk("R4 capture b at fall", rd_data_b, 4'hF);

    // R7: preload beats a normal write to another entry
    pre_en = 1'b1; pre_addr = 2'd1; pre_data = 4'h9;
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 4'h6;
    rd_addr_a = 2'd1; rd_addr_b = 2'd2;
    step();
    chk("R7 preload wins", rd_data_a, 4'h9);
    chk("R7 write dropped", rd_data_b, 4'h0);
    // R7: same entry conflict
    pre_addr = 2'd3; pre_data = 4'hC;
    wr_addr = 2'd3; wr_data = 4'h1;
    rd_addr_a = 2'd3; rd_addr_b = 2'd0;
    step();
    pre_en = 1'b0; wr_en = 1'b0;
    chk("R7 same entry", rd_data_a, 4'hC);
    chk("R9 r0 kept", rd_data_b, 4'h7);

    // R3: write enable low with data present
    wr_addr = 2'd0; wr_data = 4'h2;
    rd_addr_a = 2'd0;
    step();
    chk("R3 no write", rd_data_a, 4'h7);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 async a", rd_data_a, 4'h0);
    chk("R1 async b", rd_data_b, 4'h0);
    step();
    rst_n = 1'b1;
    step(); step(); step();
    rd_addr_a = 2'd0; rd_addr_b = 2'd1;
    step();
    chk("R1 cleared r0", rd_data_a, 4'h0);
    chk("R1 cleared r1", rd_data_b, 4'h0);
    rd_addr_a = 2'd3; rd_addr_b = 2'd2;
    step();
    chk("R1 cleared r3", rd_data_a, 4'h0);
    chk("R1 cleared r2", rd_data_b, 4'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule